// File: doc/BRIEF.md
# Operate Unit with Condition Codes

This block carries out the three operate instructions of a small 16-bit register machine (add, bitwise and, bitwise complement) and keeps the machine's three condition flags. An instruction word arrives with a valid strobe. The block decodes it and reads its operands from an internal file of eight registers. The second operand is either a register or a sign-extended 5-bit immediate. The result is written back to the destination register, and the same value is reported on a write-back port one clock later.

The flags are Negative, Zero and Positive, and exactly one of them is set at any time. They follow whichever value was last written to a register. That value can come from an operate instruction or from a load or address-calculation result that the surrounding pipeline delivers on a separate load-result port. When the presented instruction word is a conditional branch, a combinational branch-test output reports whether any flag chosen by the branch's mask is currently set.

Top module: `opu_cc_unit`

## Requirements
- R1: After reset all eight registers read as zero, the flags bus `cc` (bit 2 = N, bit 1 = Z, bit 0 = P) reads 3'b010, and `wb_valid` is low.
- R2: A word with opcode 4'b0001 in [15:12] and bit 5 clear adds R[[8:6]] and R[[2:0]] modulo 2^16 and writes the sum to R[[11:9]]. On the next clock `wb_valid` is high, `wb_dst` is [11:9] and `wb_data` holds the sum.
- R3: When bit 5 is set, the add (4'b0001) and the and (4'b0101) take the sign-extended value of [4:0] as the second operand instead of a register. With bit 5 clear, the and combines R[[8:6]] and R[[2:0]] bitwise.
- R4: Opcode 4'b1001 writes the bitwise complement of R[[8:6]] to R[[11:9]], reported on the write-back port like R2.
- R5: Exactly one flag is set at all times. After a register write, N is set if bit 15 of the written value is 1, Z is set if the value is zero, and P is set otherwise. The new flags are visible on the clock after the write.
- R6: When `ld_valid` is high, `ld_data` is written to R[`ld_dst`] and the flags are set from `ld_data` as in R5. A load alone leaves `wb_valid` low.
- R7: When no register write happens in a cycle, the flags keep their value. A valid word with any other opcode (for example 4'b0011) writes no register and does not raise `wb_valid`.
- R8: `br_taken` is high, in the same cycle, exactly when `op_valid` is high, the opcode is 4'b0000, and a flag is set whose mask bit is set (bit 11 = N, bit 10 = Z, bit 9 = P). A mask of 3'b111 is therefore always taken and 3'b000 is never taken.
- R9: When a load and an operate instruction arrive in the same cycle, the load is treated as older. An operand register equal to `ld_dst` reads `ld_data`. If both target the same register, the register holds the operate result. In every case the flags follow the operate result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Instruction word is present this cycle |
| op_word | input | 16 | Instruction word |
| ld_valid | input | 1 | Load or address result to be written this cycle |
| ld_dst | input | 3 | Destination register of the load result |
| ld_data | input | 16 | Load result value |
| wb_valid | output | 1 | An operate result was written on the last clock |
| wb_dst | output | 3 | Destination of the reported operate result |
| wb_data | output | 16 | Reported operate result |
| cc | output | 3 | Flags {N, Z, P} |
| br_taken | output | 1 | Branch test result for the presented word |

## Verification
The two functions that can collide are the load-result write and the operate write-back, because both update the register file and the flags on the same clock edge. The bench drives a load and an operate instruction in the same cycle in three arrangements. In the first, the operate reads the register being loaded, and the bench expects the forwarded value. In the second, both target the same register, and a later read must return the operate result. In the third, they target different registers, and the bench expects the flags to follow the operate result while the loaded register still holds the load value.

// File: rtl/opu_pkg.sv
package opu_pkg;
   localparam int INSTR_W  = 16;
   localparam int REG_AW   = 3;
   localparam int NREG     = 1 << REG_AW;
   localparam int IMM_W    = 5;
   localparam int OPC_MSB  = 15;
   localparam int OPC_LSB  = 12;
   localparam int DST_LSB  = 9;
   localparam int SA_LSB   = 6;
   localparam int SB_LSB   = 0;
   localparam int IMM_SEL  = 5;

   typedef enum logic [3:0] {
      OPC_BR  = 4'b0000,
      OPC_ADD = 4'b0001,
      OPC_AND = 4'b0101,
      OPC_NOT = 4'b1001
   } opc_e;

   typedef enum logic [1:0] {
      FN_ADD = 2'd0,
      FN_AND = 2'd1,
      FN_NOT = 2'd2
   } alu_fn_e;

   typedef struct packed {
      logic n;
      logic z;
      logic p;
   } cc_t;

   localparam cc_t CC_RESET = '{n: 1'b0, z: 1'b1, p: 1'b0};
endpackage

// File: rtl/opu_decode.sv
module opu_decode
   import opu_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic                valid,
   input  logic [INSTR_W-1:0]  word,
   output logic                op_we,
   output alu_fn_e             fn,
   output logic [REG_AW-1:0]   dst,
   output logic [REG_AW-1:0]   sa,
   output logic [REG_AW-1:0]   sb,
   output logic                use_imm,
   output logic [DATA_W-1:0]   imm,
   output logic                is_br,
   output logic [2:0]          mask
);
   logic [3:0] opc;

   assign opc  = word[OPC_MSB:OPC_LSB];
   assign dst  = word[DST_LSB +: REG_AW];
   assign sa   = word[SA_LSB +: REG_AW];
   assign sb   = word[SB_LSB +: REG_AW];
   assign mask = word[DST_LSB +: 3];
   assign imm  = {{(DATA_W-IMM_W){word[IMM_W-1]}}, word[IMM_W-1:0]};

   always_comb begin
      op_we   = 1'b0;
      fn      = FN_ADD;
      use_imm = 1'b0;
      is_br   = 1'b0;
      case (opc)
         OPC_ADD: begin
            op_we   = valid;
            fn      = FN_ADD;
            use_imm = word[IMM_SEL];
         end
         OPC_AND: begin
            op_we   = valid;
            fn      = FN_AND;
            use_imm = word[IMM_SEL];
         end
         OPC_NOT: begin
            op_we   = valid;
            fn      = FN_NOT;
         end
         OPC_BR: begin
            is_br   = valid;
         end
         default: begin
            op_we   = 1'b0;
         end
      endcase
   end
endmodule

// File: rtl/opu_regfile.sv
module opu_regfile
   import opu_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [REG_AW-1:0]  ra,
   input  logic [REG_AW-1:0]  rb,
   output logic [DATA_W-1:0]  rd_a,
   output logic [DATA_W-1:0]  rd_b,
   input  logic               ld_we,
   input  logic [REG_AW-1:0]  ld_dst,
   input  logic [DATA_W-1:0]  ld_data,
   input  logic               op_we,
   input  logic [REG_AW-1:0]  op_dst,
   input  logic [DATA_W-1:0]  op_data
);
   logic [NREG-1:0][DATA_W-1:0] q;

   // older load result is forwarded to a same-cycle operand read
   assign rd_a = (ld_we && ld_dst == ra) ? ld_data : q[ra];
   assign rd_b = (ld_we && ld_dst == rb) ? ld_data : q[rb];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else begin
         for (int r = 0; r < NREG; r++) begin
            if (op_we && op_dst == REG_AW'(r)) begin
               q[r] <= op_data;
            end else if (ld_we && ld_dst == REG_AW'(r)) begin
               q[r] <= ld_data;
            end
         end
      end
   end
endmodule

// File: rtl/opu_alu.sv
module opu_alu
   import opu_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter bit RIPPLE_ADD = 1'b0
) (
   input  alu_fn_e            fn,
   input  logic [DATA_W-1:0]  a,
   input  logic [DATA_W-1:0]  b,
   output logic [DATA_W-1:0]  y
);
   logic [DATA_W-1:0] sum;

   if (RIPPLE_ADD) begin : g_ripple
      logic [DATA_W-1:0] c;
      assign c[0] = 1'b0;
      for (genvar i = 0; i < DATA_W; i++) begin : g_bit
         assign sum[i] = a[i] ^ b[i] ^ c[i];
         if (i < DATA_W - 1) begin : g_carry
            assign c[i+1] = (a[i] & b[i]) | (c[i] & (a[i] ^ b[i]));
         end
      end
   end else begin : g_behav
      assign sum = a + b;
   end

   always_comb begin
      case (fn)
         FN_ADD:  y = sum;
         FN_AND:  y = a & b;
         FN_NOT:  y = ~a;
         default: y = sum;
      endcase
   end
endmodule

// File: rtl/opu_ccreg.sv
module opu_ccreg
   import opu_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               op_we,
   input  logic [DATA_W-1:0]  op_val,
   input  logic               ld_we,
   input  logic [DATA_W-1:0]  ld_val,
   output cc_t                cc
);
   logic [DATA_W-1:0] src;
   cc_t               nxt;

   // the younger operate result wins over a same-cycle load
   assign src   = op_we ? op_val : ld_val;
   assign nxt.n = src[DATA_W-1];
   assign nxt.z = (src == '0);
   assign nxt.p = !src[DATA_W-1] && (src != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cc <= CC_RESET;
      end else if (op_we || ld_we) begin
         cc <= nxt;
      end
   end
endmodule

// File: rtl/opu_cc_unit.sv
module opu_cc_unit
   import opu_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter bit RIPPLE_ADD = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               op_valid,
   input  logic [15:0]        op_word,
   input  logic               ld_valid,
   input  logic [2:0]         ld_dst,
   input  logic [DATA_W-1:0]  ld_data,
   output logic               wb_valid,
   output logic [2:0]         wb_dst,
   output logic [DATA_W-1:0]  wb_data,
   output logic [2:0]         cc,
   output logic               br_taken
);
   if (DATA_W <= IMM_W) begin : g_bad_width
      $error("opu_cc_unit: DATA_W must exceed the immediate width");
   end
   if (INSTR_W != 16 || REG_AW != 3) begin : g_bad_fmt
      $error("opu_cc_unit: instruction field layout mismatch");
   end

   logic              op_we;
   alu_fn_e           fn;
   logic [2:0]        dst, sa, sb, mask;
   logic              use_imm, is_br;
   logic [DATA_W-1:0] imm, rd_a, rd_b, opnd_b, res;
   cc_t               ccq;

   opu_decode #(.DATA_W(DATA_W)) u_dec (
      .valid(op_valid), .word(op_word), .op_we(op_we), .fn(fn),
      .dst(dst), .sa(sa), .sb(sb), .use_imm(use_imm), .imm(imm),
      .is_br(is_br), .mask(mask)
   );

   opu_regfile #(.DATA_W(DATA_W)) u_rf (
      .clk(clk), .rst_n(rst_n), .ra(sa), .rb(sb), .rd_a(rd_a), .rd_b(rd_b),
      .ld_we(ld_valid), .ld_dst(ld_dst), .ld_data(ld_data),
      .op_we(op_we), .op_dst(dst), .op_data(res)
   );

   assign opnd_b = use_imm ? imm : rd_b;

   opu_alu #(.DATA_W(DATA_W), .RIPPLE_ADD(RIPPLE_ADD)) u_alu (
      .fn(fn), .a(rd_a), .b(opnd_b), .y(res)
   );

   opu_ccreg #(.DATA_W(DATA_W)) u_cc (
      .clk(clk), .rst_n(rst_n), .op_we(op_we), .op_val(res),
      .ld_we(ld_valid), .ld_val(ld_data), .cc(ccq)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wb_valid <= 1'b0;
         wb_dst   <= '0;
         wb_data  <= '0;
      end else begin
         wb_valid <= op_we;
         if (op_we) begin
            wb_dst  <= dst;
            wb_data <= res;
         end
      end
   end

   assign cc       = ccq;
   assign br_taken = is_br && ((mask & ccq) != 3'b000);
endmodule

// File: rtl/opu_cc_chk.sv
module opu_cc_chk #(
   parameter int DATA_W = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic               op_valid,
   input logic [3:0]         opc,
   input logic [2:0]         dstf,
   input logic               ld_valid,
   input logic [DATA_W-1:0]  ld_data,
   input logic               wb_valid,
   input logic [2:0]         wb_dst,
   input logic [DATA_W-1:0]  wb_data,
   input logic [2:0]         cc,
   input logic               br_taken
);
   function automatic logic [2:0] sign_of(input logic [DATA_W-1:0] v);
      if (v[DATA_W-1]) return 3'b100;
      else if (v == '0) return 3'b010;
      else return 3'b001;
   endfunction

   logic writes_op;
   assign writes_op = op_valid && (opc == 4'b0001 || opc == 4'b0101 || opc == 4'b1001);

   a_r5_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(cc) == 1);

   a_r5_flags_follow_wb: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |-> cc == sign_of(wb_data));

   a_r2_wb_next: assert property (@(posedge clk) disable iff (!rst_n)
      writes_op |=> wb_valid && wb_dst == $past(dstf));

   a_r7_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!writes_op && !ld_valid) |=> $stable(cc));

   a_r6_load_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_valid && !writes_op) |=> cc == sign_of($past(ld_data)) && !wb_valid);

   a_r8_branch_only: assert property (@(posedge clk) disable iff (!rst_n)
      !(op_valid && opc == 4'b0000) |-> !br_taken);
endmodule

bind opu_cc_unit opu_cc_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opc(op_word[15:12]),
   .dstf(op_word[11:9]), .ld_valid(ld_valid), .ld_data(ld_data),
   .wb_valid(wb_valid), .wb_dst(wb_dst), .wb_data(wb_data), .cc(cc),
   .br_taken(br_taken)
);

// File: tb/sim_opu_cc_unit.sv
`timescale 1ns/1ps
module sim_opu_cc_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [15:0] op_word = '0;
   logic        ld_valid = 1'b0;
   logic [2:0]  ld_dst = '0;
   logic [15:0] ld_data = '0;
   logic        wb_valid;
   logic [2:0]  wb_dst;
   logic [15:0] wb_data;
   logic [2:0]  cc;
   logic        br_taken;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   localparam logic [2:0] N = 3'b100, Z = 3'b010, P = 3'b001;

   always #5 clk = ~clk;

   opu_cc_unit u0 (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_word(op_word),
      .ld_valid(ld_valid), .ld_dst(ld_dst), .ld_data(ld_data),
      .wb_valid(wb_valid), .wb_dst(wb_dst), .wb_data(wb_data),
      .cc(cc), .br_taken(br_taken)
   );

   function automatic logic [15:0] w_add_r(int d, int a, int b);
      return {4'b0001, 3'(d), 3'(a), 3'b000, 3'(b)};
   endfunction
   function automatic logic [15:0] w_add_i(int d, int a, int imm);
      return {4'b0001, 3'(d), 3'(a), 1'b1, 5'(imm)};
   endfunction
   function automatic logic [15:0] w_and_i(int d, int a, int imm);
      return {4'b0101, 3'(d), 3'(a), 1'b1, 5'(imm)};
   endfunction
   function automatic logic [15:0] w_and_r(int d, int a, int b);
      return {4'b0101, 3'(d), 3'(a), 3'b000, 3'(b)};
   endfunction
   function automatic logic [15:0] w_not(int d, int a);
      return {4'b1001, 3'(d), 3'(a), 6'b111111};
   endfunction

   task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic issue(logic [15:0] w);
      @(negedge clk);
      op_valid = 1'b1; op_word = w;
      @(negedge clk);
      op_valid = 1'b0;
   endtask

   task automatic load(int r, logic [15:0] v);
      @(negedge clk);
      ld_valid = 1'b1; ld_dst = 3'(r); ld_data = v;
      @(negedge clk);
      ld_valid = 1'b0;
   endtask

   task automatic both(int r, logic [15:0] v, logic [15:0] w);
      @(negedge clk);
      ld_valid = 1'b1; ld_dst = 3'(r); ld_data = v;
      op_valid = 1'b1; op_word = w;
      @(negedge clk);
      ld_valid = 1'b0; op_valid = 1'b0;
   endtask

   task automatic read_reg(string tag, int r, logic [15:0] exp);
      issue(w_add_i(r, r, 0));
      check(tag, wb_data, exp);
   endtask

   task automatic op_check(string tag, logic [15:0] w, logic [15:0] exp, logic [2:0] f);
      issue(w);
      check({tag, " data"}, wb_data, exp);
      check({tag, " flags"}, {13'd0, cc}, {13'd0, f});
   endtask

   task automatic br_check(string tag, logic vld, logic [15:0] w, logic exp);
      @(negedge clk);
      op_valid = vld; op_word = w;
      #1;
      check(tag, {15'd0, br_taken}, {15'd0, exp});
      op_valid = 1'b0;
   endtask

   task automatic t_reset;
      check("R1 cc", {13'd0, cc}, {13'd0, Z});
      check("R1 wb_valid", {15'd0, wb_valid}, 16'd0);
      read_reg("R1 reg3 zero", 3, 16'h0000);
      check("R1 cc after zero read", {13'd0, cc}, {13'd0, Z});
   endtask

   task automatic t_loads;
      load(1, 16'h0005);
      check("R6 cc positive", {13'd0, cc}, {13'd0, P});
      check("R6 no wb", {15'd0, wb_valid}, 16'd0);
      load(2, 16'hFFFE);
      check("R6 cc negative", {13'd0, cc}, {13'd0, N});
   endtask

   task automatic t_add;
      op_check("R2 add reg", w_add_r(3, 1, 2), 16'h0003, P);
      check("R2 wb_dst", {13'd0, wb_dst}, 16'd3);
      check("R2 wb_valid", {15'd0, wb_valid}, 16'd1);
      load(7, 16'h7FFF);
      op_check("R2 wrap", w_add_i(7, 7, 1), 16'h8000, N);
   endtask

   task automatic t_imm;
      op_check("R3 add neg imm", w_add_i(4, 1, -16), 16'hFFF5, N);
      op_check("R3 and imm", w_and_i(5, 2, 15), 16'h000E, P);
      op_check("R3 and imm ones", w_and_i(6, 2, -1), 16'hFFFE, N);
      op_check("R3 and reg", w_and_r(6, 2, 3), 16'h0002, P);
      op_check("R3 and zero", w_and_i(0, 1, 0), 16'h0000, Z);
   endtask

   task automatic t_not;
      op_check("R4 not", w_not(6, 1), 16'hFFFA, N);
      op_check("R4 not neg", w_not(4, 4), 16'h000A, P);
   endtask

   task automatic t_hold;
      issue({4'b0011, 3'd5, 3'd0, 6'd0});
      check("R7 other opcode no wb", {15'd0, wb_valid}, 16'd0);
      check("R7 cc held", {13'd0, cc}, {13'd0, P});
      @(negedge clk);
      check("R7 cc idle", {13'd0, cc}, {13'd0, P});
      read_reg("R7 reg5 untouched", 5, 16'h000E);
   endtask

   task automatic t_branch;
      br_check("R8 mask p", 1'b1, {4'b0000, 3'b001, 9'd0}, 1'b1);
      br_check("R8 mask n", 1'b1, {4'b0000, 3'b100, 9'd0}, 1'b0);
      br_check("R8 mask all", 1'b1, {4'b0000, 3'b111, 9'd0}, 1'b1);
      br_check("R8 mask none", 1'b1, {4'b0000, 3'b000, 9'd0}, 1'b0);
      br_check("R8 not branch", 1'b1, {4'b0001, 3'b111, 9'd0}, 1'b0);
      br_check("R8 invalid", 1'b0, {4'b0000, 3'b111, 9'd0}, 1'b0);
      issue(w_and_i(0, 0, 0));
      br_check("R8 mask z", 1'b1, {4'b0000, 3'b010, 9'd0}, 1'b1);
      br_check("R8 mask np", 1'b1, {4'b0000, 3'b101, 9'd0}, 1'b0);
   endtask

   task automatic t_collide;
      both(1, 16'h0100, w_add_i(2, 1, 1));
      check("R9 forward", wb_data, 16'h0101);
      both(3, 16'h8000, w_add_i(3, 0, 2));
      check("R9 same dst flags", {13'd0, cc}, {13'd0, P});
      read_reg("R9 same dst value", 3, 16'h0002);
      both(4, 16'h0000, w_add_i(5, 0, -1));
      check("R9 flags follow op", {13'd0, cc}, {13'd0, N});
      read_reg("R9 load kept", 4, 16'h0000);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_loads();
      t_add();
      t_imm();
      t_not();
      t_hold();
      t_branch();
      t_collide();
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule